// File: doc/BRIEF.md
# DisplayPort Link-Rate and Drive-Level Sequencer

This block takes one configuration request for a four-lane DisplayPort transmitter PHY and turns it into the PHY's static control fields. A request can carry a new link rate, new drive levels, or both. It also gives the number of active lanes, whether spread-spectrum clocking is wanted, and a swing level and a pre-emphasis level for every lane. The block first checks the request as a whole. A rejected request changes no control field.

When a rate change is asked for, the block runs a fixed sequence. It takes all lanes down and waits a settle time, then powers down the PLL. Next it programs the divider, the rate fields and the spread-spectrum fields. It then brings the PLL and the active lanes back up and polls the PLL ready input at a fixed interval until a lock limit runs out. After lock it moves the transmitter out of its test mode and releases idle on the active lanes. When drive levels are asked for, each active lane gets amplitude, amplitude-scale and emphasis codes from a level table. A single-cycle done, parameter-error or timeout pulse ends every accepted request.

The microsecond delays come from a parameter that gives clock cycles per microsecond. The analog PLL appears only as the `pll_ready` input.

Top module: `dp_link_seq`

## Requirements
- R1: After reset, `tx_idle` and `tx_pd` are 4'hF, `pll_pd` is 1, `tx_mode` is 3, and every other control field and flag is 0. `busy` is 0.
- R2: With `req_set_rate`=1, only `req_rate_mbps` of 1620 or 2700 is accepted. Any other rate gives `err_param` and leaves all control fields unchanged. With `req_set_rate`=0 the rate value is not checked.
- R3: Only `req_lanes` of 1, 2 or 4 is accepted. Lane count n makes lanes 0..n-1 active. Any other count gives `err_param` and changes nothing.
- R4: With `req_set_levels`=1, every active lane's swing and pre-emphasis (3 bits each, lane i at bits [3i+2:3i]) must each be at most 3, and their sum must be at most 3. Otherwise the block gives `err_param` and writes nothing. Inactive lanes are not checked.
- R5: A rate change goes through these steps in order: all lanes idle and powered down; a settle wait of WAIT_US; `tx_mode`=3 and `pll_pd`=1; divider and rate fields; spread-spectrum fields; `pll_pd`=0 while all lanes are still powered down; power-down released on the active lanes only.
- R6: At 1620 the block sets `pll_div`=15'h4380 and `rate_sel`=1. At 2700 it sets `pll_div`=15'h3840 and `rate_sel`=0. Both rates set `tx_rterm`=1, `ref_div`=0, `pll_ctl`=16'h0800 and `tx_ctl`=0.
- R7: With `req_ssc`=1 the block sets `ssc_depth`=9, `ssc_en`=1 and `ssc_cnt`=10'h17D. With `req_ssc`=0 only `ssc_en` is cleared, and depth and count keep their values.
- R8: `pll_ready` is sampled once every WAIT_US, at most LOCK_POLLS times. If it is never seen high, the block pulses `err_timeout` about (LOCK_POLLS+1)×WAIT_US after acceptance. `tx_mode` stays 3, `tx_idle` stays 4'hF and no levels are written. A lock seen at any sample continues the sequence.
- R9: After lock, `tx_mode` becomes 0. `tx_idle` and `tx_pd` are 0 on the active lanes and 1 on the inactive lanes. A lane is never out of idle while it is powered down.
- R10: The level table maps (swing,pre) to (amp,scale,emphasis) as follows. Swing 0: pre 0→(1,1,0), 1→(2,1,4), 2→(3,1,8), 3→(4,1,13). Swing 1: 0→(3,1,0), 1→(5,1,7), 2→(6,1,6). Swing 2: 0→(5,1,0), 1→(7,1,4). Swing 3: 0→(7,1,0).
- R11: Levels are written only to active lanes, and inactive lanes keep their previous codes. Lane i uses `lane_emp`[4i+3:4i], `lane_amp`[3i+2:3i] and `lane_scale`[2i+1:2i]. When both rate and levels are requested, the levels are written after lock.
- R12: A request is accepted only while `busy`=0, and requests made while busy are ignored. Each accepted request ends with exactly one single-cycle pulse on `done`, `err_param` or `err_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe (taken only when idle) |
| req_set_rate | input | 1 | Request asks for a rate change |
| req_rate_mbps | input | 12 | Link rate per lane in Mb/s |
| req_lanes | input | 3 | Active lane count |
| req_ssc | input | 1 | Enable spread-spectrum clocking |
| req_set_levels | input | 1 | Request asks for new drive levels |
| req_swing | input | 12 | Swing level, 3 bits per lane |
| req_pre | input | 12 | Pre-emphasis level, 3 bits per lane |
| pll_ready | input | 1 | PLL lock indication |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Request completed (pulse) |
| err_param | output | 1 | Request rejected (pulse) |
| err_timeout | output | 1 | PLL lock not seen (pulse) |
| tx_idle | output | 4 | Per-lane idle control |
| tx_pd | output | 4 | Per-lane power-down |
| pll_pd | output | 1 | PLL power-down |
| tx_mode | output | 2 | Transmitter mode |
| pll_div | output | 15 | PLL feedback divider |
| rate_sel | output | 2 | Rate select |
| tx_rterm | output | 3 | Transmitter termination code |
| ref_div | output | 4 | Reference divider |
| pll_ctl | output | 16 | PLL control word |
| tx_ctl | output | 16 | Transmitter control word |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_cnt | output | 10 | Spread-spectrum count |
| lane_emp | output | 16 | Emphasis code, 4 bits per lane |
| lane_amp | output | 12 | Amplitude code, 3 bits per lane |
| lane_scale | output | 8 | Amplitude scale, 2 bits per lane |

## Verification
The assertions assume that `pll_ready` is a level that software-visible logic samples. They assume no particular relation between `pll_ready` and the sequence. They also assume that requests may arrive at any time, including while the block is busy. The ordering properties depend only on the block's own outputs and on `pll_ready` at the lock sample. The stimulus holds `pll_ready` steady across each poll window, except in one test that raises it partway through polling. It sends a stray invalid request during a running sequence, so the ignore-while-busy behaviour is exercised as well.

// File: rtl/dp_link_seq_pkg.sv
package dp_link_seq_pkg;

    localparam int NLANE = 4;

    localparam logic [11:0] RATE_LO_MBPS = 12'd1620;
    localparam logic [11:0] RATE_HI_MBPS = 12'd2700;
    localparam logic [14:0] DIV_LO       = 15'h4380;
    localparam logic [14:0] DIV_HI       = 15'h3840;
    localparam logic [15:0] PLL_CTL_VAL  = 16'h0800;
    localparam logic [3:0]  SSC_DEPTH_ON = 4'd9;
    localparam logic [9:0]  SSC_CNT_ON   = 10'h17D;

    typedef struct packed {
        logic [2:0] amp;
        logic [1:0] scale;
        logic [3:0] emp;
    } lvl_code_t;

    typedef enum logic [3:0] {
        S_IDLE, S_QUIESCE, S_SETTLE, S_PLL_OFF, S_PROG,
        S_SSC, S_PLL_ON, S_LANES_ON, S_POLL, S_LEVELS
    } seq_st_e;

    typedef struct packed {
        logic [NLANE-1:0]   tx_idle;
        logic [NLANE-1:0]   tx_pd;
        logic               pll_pd;
        logic [1:0]         tx_mode;
        logic [14:0]        pll_div;
        logic [1:0]         rate_sel;
        logic [2:0]         tx_rterm;
        logic [3:0]         ref_div;
        logic [15:0]        pll_ctl;
        logic [15:0]        tx_ctl;
        logic [3:0]         ssc_depth;
        logic               ssc_en;
        logic [9:0]         ssc_cnt;
        logic [4*NLANE-1:0] lane_emp;
        logic [3*NLANE-1:0] lane_amp;
        logic [2*NLANE-1:0] lane_scale;
    } ctl_t;

    function automatic ctl_t ctl_reset();
        ctl_t c;
        c         = '0;
        c.tx_idle = '1;
        c.tx_pd   = '1;
        c.pll_pd  = 1'b1;
        c.tx_mode = 2'd3;
        return c;
    endfunction

    // swing/pre table; combinations over the limit never reach it
    function automatic lvl_code_t lvl_lookup(input logic [1:0] sw, input logic [1:0] pe);
        lvl_code_t r;
        case ({sw, pe})
            4'b00_00: r = '{3'd1, 2'd1, 4'h0};
            4'b00_01: r = '{3'd2, 2'd1, 4'h4};
            4'b00_10: r = '{3'd3, 2'd1, 4'h8};
            4'b00_11: r = '{3'd4, 2'd1, 4'hD};
            4'b01_00: r = '{3'd3, 2'd1, 4'h0};
            4'b01_01: r = '{3'd5, 2'd1, 4'h7};
            4'b01_10: r = '{3'd6, 2'd1, 4'h6};
            4'b10_00: r = '{3'd5, 2'd1, 4'h0};
            4'b10_01: r = '{3'd7, 2'd1, 4'h4};
            4'b11_00: r = '{3'd7, 2'd1, 4'h0};
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dp_req_check.sv
module dp_req_check
    import dp_link_seq_pkg::*;
(
    input  logic               set_rate,
    input  logic [11:0]        rate_mbps,
    input  logic [2:0]         lanes,
    input  logic               set_levels,
    input  logic [3*NLANE-1:0] swing,
    input  logic [3*NLANE-1:0] pre,
    output logic               ok,
    output logic [NLANE-1:0]   lane_mask
);
    logic             lanes_ok;
    logic             rate_ok;
    logic [NLANE-1:0] lane_bad;

    always_comb begin
        lanes_ok = 1'b1;
        case (lanes)
            3'd1:    lane_mask = 4'b0001;
            3'd2:    lane_mask = 4'b0011;
            3'd4:    lane_mask = 4'b1111;
            default: begin
                lane_mask = 4'b0000;
                lanes_ok  = 1'b0;
            end
        endcase
    end

    assign rate_ok = (rate_mbps == RATE_LO_MBPS) || (rate_mbps == RATE_HI_MBPS);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [2:0] sw;
        logic [2:0] pe;
        logic [3:0] sum;
        assign sw  = swing[3*i +: 3];
        assign pe  = pre[3*i +: 3];
        assign sum = {1'b0, sw} + {1'b0, pe};
        assign lane_bad[i] = (sw > 3'd3) || (pe > 3'd3) || (sum > 4'd3);
    end

    assign ok = lanes_ok && (!set_rate || rate_ok) &&
                (!set_levels || ((lane_bad & lane_mask) == '0));
endmodule

// File: rtl/dp_level_map.sv
module dp_level_map
    import dp_link_seq_pkg::*;
(
    input  logic [2*NLANE-1:0]         swing,
    input  logic [2*NLANE-1:0]         pre,
    output lvl_code_t [NLANE-1:0]      codes
);
    for (genvar i = 0; i < NLANE; i++) begin : g_map
        assign codes[i] = lvl_lookup(swing[2*i +: 2], pre[2*i +: 2]);
    end
endmodule

// File: rtl/dp_link_seq.sv
module dp_link_seq
    import dp_link_seq_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int WAIT_US    = 100,
    parameter int LOCK_POLLS = 10
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_set_rate,
    input  logic [11:0] req_rate_mbps,
    input  logic [2:0]  req_lanes,
    input  logic        req_ssc,
    input  logic        req_set_levels,
    input  logic [11:0] req_swing,
    input  logic [11:0] req_pre,
    input  logic        pll_ready,
    output logic        busy,
    output logic        done,
    output logic        err_param,
    output logic        err_timeout,
    output logic [3:0]  tx_idle,
    output logic [3:0]  tx_pd,
    output logic        pll_pd,
    output logic [1:0]  tx_mode,
    output logic [14:0] pll_div,
    output logic [1:0]  rate_sel,
    output logic [2:0]  tx_rterm,
    output logic [3:0]  ref_div,
    output logic [15:0] pll_ctl,
    output logic [15:0] tx_ctl,
    output logic [3:0]  ssc_depth,
    output logic        ssc_en,
    output logic [9:0]  ssc_cnt,
    output logic [15:0] lane_emp,
    output logic [11:0] lane_amp,
    output logic [7:0]  lane_scale
);
    localparam int WAIT_CYC = CYC_PER_US * WAIT_US;
    localparam int TW       = $clog2(WAIT_CYC + 1);
    localparam int PW       = $clog2(LOCK_POLLS + 1);

    typedef struct packed {
        seq_st_e            st;
        logic [TW-1:0]      tmr;
        logic [PW-1:0]      polls;
        logic [NLANE-1:0]   mask;
        logic               rate_hi;
        logic               ssc;
        logic               set_lv;
        logic [2*NLANE-1:0] sw;
        logic [2*NLANE-1:0] pe;
        ctl_t               ctl;
        logic               done;
        logic               perr;
        logic               tout;
    } seq_t;

    seq_t q, d;

    logic                  req_ok;
    logic [NLANE-1:0]      req_mask;
    lvl_code_t [NLANE-1:0] codes;

    dp_req_check u_check (
        .set_rate   (req_set_rate),
        .rate_mbps  (req_rate_mbps),
        .lanes      (req_lanes),
        .set_levels (req_set_levels),
        .swing      (req_swing),
        .pre        (req_pre),
        .ok         (req_ok),
        .lane_mask  (req_mask)
    );

    dp_level_map u_map (
        .swing (q.sw),
        .pre   (q.pe),
        .codes (codes)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.perr = 1'b0;
        d.tout = 1'b0;
        case (q.st)
            S_IDLE: if (req_valid) begin
                if (!req_ok) begin
                    d.perr = 1'b1;
                end else begin
                    d.mask    = req_mask;
                    d.rate_hi = (req_rate_mbps == RATE_HI_MBPS);
                    d.ssc     = req_ssc;
                    d.set_lv  = req_set_levels;
                    for (int i = 0; i < NLANE; i++) begin
                        d.sw[2*i +: 2] = req_swing[3*i +: 2];
                        d.pe[2*i +: 2] = req_pre[3*i +: 2];
                    end
                    if (req_set_rate)        d.st = S_QUIESCE;
                    else if (req_set_levels) d.st = S_LEVELS;
                    else                     d.done = 1'b1;
                end
            end
            S_QUIESCE: begin
                d.ctl.tx_idle = '1;
                d.ctl.tx_pd   = '1;
                d.tmr         = TW'(WAIT_CYC - 1);
                d.st          = S_SETTLE;
            end
            S_SETTLE: begin
                if (q.tmr == '0) d.st = S_PLL_OFF;
                else             d.tmr = q.tmr - 1'b1;
            end
            S_PLL_OFF: begin
                d.ctl.tx_mode = 2'd3;
                d.ctl.pll_pd  = 1'b1;
                d.st          = S_PROG;
            end
            S_PROG: begin
                d.ctl.pll_div  = q.rate_hi ? DIV_HI : DIV_LO;
                d.ctl.rate_sel = q.rate_hi ? 2'd0 : 2'd1;
                d.ctl.tx_rterm = 3'd1;
                d.ctl.ref_div  = 4'd0;
                d.ctl.pll_ctl  = PLL_CTL_VAL;
                d.ctl.tx_ctl   = 16'h0000;
                d.st           = S_SSC;
            end
            S_SSC: begin
                d.ctl.ssc_en = q.ssc;
                if (q.ssc) begin
                    d.ctl.ssc_depth = SSC_DEPTH_ON;
                    d.ctl.ssc_cnt   = SSC_CNT_ON;
                end
                d.st = S_PLL_ON;
            end
            S_PLL_ON: begin
                d.ctl.pll_pd = 1'b0;
                d.st         = S_LANES_ON;
            end
            S_LANES_ON: begin
                d.ctl.tx_pd = ~q.mask;
                d.tmr       = TW'(WAIT_CYC - 1);
                d.polls     = '0;
                d.st        = S_POLL;
            end
            S_POLL: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (pll_ready) begin
                    d.ctl.tx_mode = 2'd0;
                    d.ctl.tx_idle = ~q.mask;
                    if (q.set_lv) begin
                        d.st = S_LEVELS;
                    end else begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end else if (q.polls == PW'(LOCK_POLLS - 1)) begin
                    d.tout = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.polls = q.polls + 1'b1;
                    d.tmr   = TW'(WAIT_CYC - 1);
                end
            end
            S_LEVELS: begin
                for (int i = 0; i < NLANE; i++) begin
                    if (q.mask[i]) begin
                        d.ctl.lane_emp[4*i +: 4]   = codes[i].emp;
                        d.ctl.lane_amp[3*i +: 3]   = codes[i].amp;
                        d.ctl.lane_scale[2*i +: 2] = codes[i].scale;
                    end
                end
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.ctl <= ctl_reset();
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign err_param   = q.perr;
    assign err_timeout = q.tout;
    assign tx_idle     = q.ctl.tx_idle;
    assign tx_pd       = q.ctl.tx_pd;
    assign pll_pd      = q.ctl.pll_pd;
    assign tx_mode     = q.ctl.tx_mode;
    assign pll_div     = q.ctl.pll_div;
    assign rate_sel    = q.ctl.rate_sel;
    assign tx_rterm    = q.ctl.tx_rterm;
    assign ref_div     = q.ctl.ref_div;
    assign pll_ctl     = q.ctl.pll_ctl;
    assign tx_ctl      = q.ctl.tx_ctl;
    assign ssc_depth   = q.ctl.ssc_depth;
    assign ssc_en      = q.ctl.ssc_en;
    assign ssc_cnt     = q.ctl.ssc_cnt;
    assign lane_emp    = q.ctl.lane_emp;
    assign lane_amp    = q.ctl.lane_amp;
    assign lane_scale  = q.ctl.lane_scale;
endmodule

// File: rtl/dp_link_seq_chk.sv
module dp_link_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pll_ready,
    input logic        busy,
    input logic        done,
    input logic        err_param,
    input logic        err_timeout,
    input logic [3:0]  tx_idle,
    input logic [3:0]  tx_pd,
    input logic        pll_pd,
    input logic [1:0]  tx_mode,
    input logic [14:0] pll_div,
    input logic [15:0] lane_emp,
    input logic [11:0] lane_amp,
    input logic [7:0]  lane_scale
);
    // R12
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_param, err_timeout}));

    // R5
    pll_up_lanes_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pd) |-> (tx_pd == 4'hF && tx_mode == 2'd3));

    // R8
    mode_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_mode[1]) |-> $past(pll_ready));

    // R9
    idle_implies_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~tx_idle & ~tx_pd) == (~tx_idle));

    // R2
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_param |-> ($stable(pll_div) && $stable(lane_emp) && $stable(lane_amp)
                       && $stable(lane_scale) && $stable(tx_pd) && $stable(tx_idle)));

    // R8
    timeout_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (tx_mode == 2'd3 && tx_idle == 4'hF && !busy));
endmodule

bind dp_link_seq dp_link_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_ready   (pll_ready),
    .busy        (busy),
    .done        (done),
    .err_param   (err_param),
    .err_timeout (err_timeout),
    .tx_idle     (tx_idle),
    .tx_pd       (tx_pd),
    .pll_pd      (pll_pd),
    .tx_mode     (tx_mode),
    .pll_div     (pll_div),
    .lane_emp    (lane_emp),
    .lane_amp    (lane_amp),
    .lane_scale  (lane_scale)
);

// File: tb/dp_link_seq_bench.sv
`timescale 1ns/1ps
module dp_link_seq_bench;
    localparam int CPU = 2;
    localparam int W   = CPU * 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_set_rate = 1'b0, req_ssc = 1'b0, req_set_levels = 1'b0;
    logic [11:0] req_rate_mbps = '0, req_swing = '0, req_pre = '0;
    logic [2:0]  req_lanes = '0;
    logic        pll_ready = 1'b1;
    logic        busy, done, err_param, err_timeout, pll_pd, ssc_en;
    logic [3:0]  tx_idle, tx_pd, ref_div, ssc_depth;
    logic [1:0]  tx_mode, rate_sel;
    logic [14:0] pll_div;
    logic [2:0]  tx_rterm;
    logic [15:0] pll_ctl, tx_ctl, lane_emp;
    logic [9:0]  ssc_cnt;
    logic [11:0] lane_amp;
    logic [7:0]  lane_scale;

    dp_link_seq #(.CYC_PER_US(CPU), .WAIT_US(100), .LOCK_POLLS(10)) u_dp_link_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set_rate(req_set_rate),
        .req_rate_mbps(req_rate_mbps), .req_lanes(req_lanes), .req_ssc(req_ssc),
        .req_set_levels(req_set_levels), .req_swing(req_swing), .req_pre(req_pre),
        .pll_ready(pll_ready), .busy(busy), .done(done), .err_param(err_param),
        .err_timeout(err_timeout), .tx_idle(tx_idle), .tx_pd(tx_pd), .pll_pd(pll_pd),
        .tx_mode(tx_mode), .pll_div(pll_div), .rate_sel(rate_sel), .tx_rterm(tx_rterm),
        .ref_div(ref_div), .pll_ctl(pll_ctl), .tx_ctl(tx_ctl), .ssc_depth(ssc_depth),
        .ssc_en(ssc_en), .ssc_cnt(ssc_cnt), .lane_emp(lane_emp), .lane_amp(lane_amp),
        .lane_scale(lane_scale)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, n_done = 0, n_perr = 0, n_tout = 0, t_tout = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (done)        n_done <= n_done + 1;
        if (err_param)   n_perr <= n_perr + 1;
        if (err_timeout) begin n_tout <= n_tout + 1; t_tout <= cyc; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic sr, input logic [11:0] rate, input logic [2:0] ln,
                        input logic ssc, input logic slv, input logic [11:0] sw,
                        input logic [11:0] pe);
        @(negedge clk);
        req_valid = 1'b1; req_set_rate = sr; req_rate_mbps = rate; req_lanes = ln;
        req_ssc = ssc; req_set_levels = slv; req_swing = sw; req_pre = pe;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // waits until the total of outcomes grows; returns 0 done, 1 param, 2 timeout
    task automatic wait_end(output int kind);
        int base = n_done + n_perr + n_tout;
        int d0 = n_done, p0 = n_perr;
        kind = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            #1;
            if (n_done + n_perr + n_tout != base) begin
                kind = (n_done != d0) ? 0 : (n_perr != p0) ? 1 : 2;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 tx_idle", tx_idle, 4'hF);  chk("R1 tx_pd", tx_pd, 4'hF);
        chk("R1 pll_pd", pll_pd, 1);       chk("R1 tx_mode", tx_mode, 3);
        chk("R1 pll_div", pll_div, 0);     chk("R1 lane_emp", lane_emp, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_bad_rate();
        int k;
        send(1, 12'd2000, 3'd4, 0, 0, 0, 0); wait_end(k);
        chk("R2 bad rate rejected", k, 1);
        chk("R2 no divider write", pll_div, 0);
        chk("R2 lanes still down", tx_pd, 4'hF);
        send(0, 12'd3000, 3'd4, 0, 0, 0, 0); wait_end(k);
        chk("R2 rate unchecked without set", k, 0);
        chk("R2 divider untouched", pll_div, 0);
    endtask

    task automatic t_bad_lanes();
        int k;
        send(1, 12'd1620, 3'd3, 0, 0, 0, 0); wait_end(k);
        chk("R3 three lanes rejected", k, 1);
        send(0, 12'd0, 3'd0, 0, 1, 0, 0); wait_end(k);
        chk("R3 zero lanes rejected", k, 1);
        chk("R3 levels untouched", lane_amp, 0);
    endtask

    task automatic t_rate_1620(input logic [3:0] exp_depth, input logic [9:0] exp_cnt);
        int k;
        send(1, 12'd1620, 3'd1, 0, 0, 0, 0); wait_end(k);
        chk("R6 1620 done", k, 0);
        chk("R6 div", pll_div, 15'h4380);  chk("R6 rate_sel", rate_sel, 1);
        chk("R6 rterm", tx_rterm, 1);      chk("R6 ref_div", ref_div, 0);
        chk("R6 pll_ctl", pll_ctl, 16'h0800); chk("R6 tx_ctl", tx_ctl, 0);
        chk("R7 ssc off", ssc_en, 0);
        chk("R7 depth kept", ssc_depth, exp_depth); chk("R7 cnt kept", ssc_cnt, exp_cnt);
        chk("R9 mode", tx_mode, 0);        chk("R9 idle", tx_idle, 4'hE);
        chk("R9 pd", tx_pd, 4'hE);         chk("R5 pll up", pll_pd, 0);
    endtask

    task automatic t_rate_2700_levels();
        int k;
        // lane0 (0,3) lane1 (1,1) lane2 (2,1) lane3 (3,0)
        send(1, 12'd2700, 3'd4, 1, 1, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd0, 3'd1, 3'd1, 3'd3});
        wait_end(k);
        chk("R6 2700 done", k, 0);
        chk("R6 div", pll_div, 15'h3840);  chk("R6 rate_sel", rate_sel, 0);
        chk("R7 ssc en", ssc_en, 1);       chk("R7 depth", ssc_depth, 9);
        chk("R7 cnt", ssc_cnt, 10'h17D);
        chk("R9 all idle off", tx_idle, 0); chk("R9 all pd off", tx_pd, 0);
        chk("R10 emp", lane_emp, 16'h047D); chk("R10 amp", lane_amp, 12'hFEC);
        chk("R10 scale", lane_scale, 8'h55);
    endtask

    task automatic t_levels();
        int k;
        send(0, 0, 3'd2, 0, 1, {3'd0, 3'd0, 3'd2, 3'd0}, {3'd0, 3'd0, 3'd2, 3'd0});
        wait_end(k);
        chk("R4 sum over 3 rejected", k, 1);
        chk("R4 levels unchanged", lane_emp, 16'h047D);
        send(0, 0, 3'd4, 0, 1, {3'd0, 3'd0, 3'd0, 3'd4}, 0); wait_end(k);
        chk("R4 swing 4 rejected", k, 1);
        // lane0 (0,0) lane1 (1,2); lane3 (3,3) inactive
        send(0, 0, 3'd2, 0, 1, {3'd3, 3'd0, 3'd1, 3'd0}, {3'd3, 3'd0, 3'd2, 3'd0});
        wait_end(k);
        chk("R4 inactive lane unchecked", k, 0);
        chk("R11 emp", lane_emp, 16'h0460); chk("R11 amp", lane_amp, 12'hFF1);
        chk("R11 scale", lane_scale, 8'h55);
        chk("R11 rate untouched", pll_div, 15'h3840);
    endtask

    task automatic t_timeout();
        int k, t0;
        pll_ready = 1'b0;
        t0 = cyc;
        send(1, 12'd2700, 3'd2, 0, 1, 0, {9'd0, 3'd1});
        wait_end(k);
        chk("R8 timeout", k, 2);
        n_chk++;
        if (t_tout - t0 < 11 * W || t_tout - t0 > 11 * W + 20) begin
            n_bad++;
            $display("FAIL R8 timeout latency: actual %0d expected %0d..%0d",
                     t_tout - t0, 11 * W, 11 * W + 20);
        end
        chk("R8 mode stays 3", tx_mode, 3); chk("R8 idle stays", tx_idle, 4'hF);
        chk("R8 pd active only", tx_pd, 4'hC);
        chk("R8 no level write", lane_emp, 16'h0460);
    endtask

    task automatic t_late_lock();
        int k;
        pll_ready = 1'b0;
        send(1, 12'd1620, 3'd2, 0, 0, 0, 0);
        repeat (5 * W) @(negedge clk);
        pll_ready = 1'b1;
        wait_end(k);
        chk("R8 late lock done", k, 0);
        chk("R9 idle", tx_idle, 4'hC); chk("R9 pd", tx_pd, 4'hC);
        chk("R9 mode", tx_mode, 0);
    endtask

    task automatic t_busy();
        int k, p0;
        p0 = n_perr;
        send(1, 12'd2700, 3'd4, 0, 0, 0, 0);
        repeat (50) @(negedge clk);
        chk("R12 busy", busy, 1);
        send(1, 12'd999, 3'd3, 0, 0, 0, 0);
        wait_end(k);
        chk("R12 first request done", k, 0);
        chk("R12 stray ignored", n_perr - p0, 0);
        chk("R12 div", pll_div, 15'h3840); chk("R12 idle", tx_idle, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_rate();
        t_bad_lanes();
        t_rate_1620(4'd0, 10'd0);
        t_rate_2700_levels();
        t_levels();
        t_rate_1620(4'd9, 10'h17D);
        t_timeout();
        t_late_lock();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule